// File: doc/BRIEF.md
# Warp Branch Lane-Mask Sequencer

This block follows the set of enabled lanes of a 32-lane lockstep group as it runs through one level of a two-way conditional and then rejoins. When a branch strobe arrives while the group is converged, the block captures the per-lane condition vector. It then enables the lanes whose condition is true. When the caller signals that the taken path is over, it switches to the complementary lanes. When the else path is over, it restores the full mask. Lane `i` always owns bit `i` of the mask.

A condition vector in which every lane agrees (all ones or all zeros) has an empty side. Such a branch spends no phase: the group stays converged with all lanes enabled. A second branch strobe that arrives while a divergence is still open is dropped and reported with a one-cycle error pulse. The block also gives a population count of the current mask every cycle, so that a monitor can compute lane efficiency. For example, a condition of "lane ID even" gives 16 of 32 lanes in each phase, which is 50 %.

All inputs are plain single-cycle control strobes. There is no valid/ready handshake, because no data stream crosses the block and it never needs to stall its caller. A strobe that arrives in a phase where it has no meaning is ignored.

Top module: `simt_div_seq`

## Requirements
- R1: After reset, `act_mask_o` is all ones, `phase_o` is 0, `act_cnt_o` is 32 and `branch_err_o` is 0. The phase encoding is 0 = converged, 1 = taken path, 2 = else path.
- R2: In phase 0, a `branch_i` pulse whose `cond_i` has both ones and zeros moves the block to phase 1 on the next cycle, with `act_mask_o` equal to the sampled `cond_i`.
- R3: In phase 1, a `taken_end_i` pulse moves the block to phase 2 on the next cycle, with `act_mask_o` equal to the bitwise complement of the condition captured in R2.
- R4: In phase 2, an `else_end_i` pulse moves the block to phase 0 on the next cycle, with `act_mask_o` all ones.
- R5: In phase 0, a `branch_i` pulse whose `cond_i` is all ones or all zeros leaves the block in phase 0 with the full mask.
- R6: A `branch_i` pulse in phase 1 or 2 leaves the phase and the mask unchanged and sets `branch_err_o` high for exactly the next cycle. In every other case `branch_err_o` is 0.
- R7: `act_cnt_o` equals the number of set bits of `act_mask_o` in the same cycle. For example, it is 16 for a mask of even lanes.
- R8: Changes on `cond_i` after the branch has been captured do not affect the phase-1 mask or the phase-2 mask.
- R9: `taken_end_i` outside phase 1 and `else_end_i` outside phase 2 have no effect on the phase or the mask.
- R10: In phases 1 and 2 the mask is never empty and never full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cond_i | input | 32 | Per-lane branch condition, bit i for lane i |
| branch_i | input | 1 | Branch strobe, samples `cond_i` |
| taken_end_i | input | 1 | End of the taken path |
| else_end_i | input | 1 | End of the else path |
| act_mask_o | output | 32 | Currently enabled lanes |
| phase_o | output | 2 | 0 converged, 1 taken, 2 else |
| act_cnt_o | output | 6 | Number of enabled lanes |
| branch_err_o | output | 1 | One-cycle pulse for a dropped nested branch |

## Verification
The assertions assume that each strobe is sampled only on the edge where it is high. They allow any combination of strobes in the same cycle. They place no constraint on `cond_i` outside the capture edge, and several properties compare the next mask with the `cond_i` value sampled one edge earlier. The stimulus drives every input at the falling clock edge. It holds a strobe for exactly one cycle, and it deliberately moves `cond_i` and fires strobes in the wrong phase, so that the ignore paths of R6, R8 and R9 are exercised without breaking those assumptions.

// File: rtl/sds_pkg.sv
package sds_pkg;

  typedef enum logic [1:0] {
    PH_CONV  = 2'd0,
    PH_TAKEN = 2'd1,
    PH_ELSE  = 2'd2
  } phase_e;

endpackage

// File: rtl/sds_popcount.sv
module sds_popcount #(
  parameter int N     = 32,
  parameter int CNT_W = $clog2(N + 1)
) (
  input  logic [N-1:0]     bits_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam int LEVELS = (N > 1) ? $clog2(N) : 1;
  localparam int PAD    = 1 << LEVELS;

  // balanced adder tree; level 0 holds the zero-padded input bits
  for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
    localparam int W = PAD >> l;
    logic [CNT_W-1:0] node [W];
    if (l == 0) begin : g_leaf
      for (genvar i = 0; i < W; i++) begin : g_bit
        if (i < N) begin : g_real
          assign node[i] = CNT_W'(bits_i[i]);
        end else begin : g_pad
          assign node[i] = '0;
        end
      end
    end else begin : g_sum
      for (genvar i = 0; i < W; i++) begin : g_add
        assign node[i] = g_lvl[l-1].node[2*i] + g_lvl[l-1].node[2*i+1];
      end
    end
  end

  assign cnt_o = g_lvl[LEVELS].node[0];

  // R7: tree sum agrees with a direct bit count
  always_comb begin
    a_popcnt_r7: assert ($countones(bits_i) == int'(cnt_o))
      else $error("popcount tree mismatch");
  end

endmodule

// File: rtl/sds_phase_ctrl.sv
module sds_phase_ctrl
  import sds_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   branch_i,
  input  logic   split_i,
  input  logic   taken_end_i,
  input  logic   else_end_i,
  output phase_e phase_o,
  output logic   ld_taken_o,
  output logic   ld_else_o,
  output logic   ld_full_o,
  output logic   err_o
);

  phase_e phase_q, phase_d;
  logic   err_q;
  logic   in_flight;

  assign in_flight = (phase_q != PH_CONV);

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_CONV:  if (branch_i && split_i) phase_d = PH_TAKEN;
      PH_TAKEN: if (taken_end_i)         phase_d = PH_ELSE;
      PH_ELSE:  if (else_end_i)          phase_d = PH_CONV;
      default:                           phase_d = PH_CONV;
    endcase
  end

  assign ld_taken_o = (phase_q == PH_CONV)  && branch_i && split_i;
  assign ld_else_o  = (phase_q == PH_TAKEN) && taken_end_i;
  assign ld_full_o  = (phase_q == PH_ELSE)  && else_end_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_CONV;
      err_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      err_q   <= in_flight && branch_i;
    end
  end

  assign phase_o = phase_q;
  assign err_o   = err_q;

  p_enter_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_CONV && branch_i && split_i) |=> (phase_q == PH_TAKEN));

  p_to_else_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_TAKEN && taken_end_i) |=> (phase_q == PH_ELSE));

  p_rejoin_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ELSE && else_end_i) |=> (phase_q == PH_CONV));

  p_uniform_stay_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_CONV && !split_i) |=> (phase_q == PH_CONV));

  p_nested_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_flight && branch_i) |=> err_q);

  p_no_spurious_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_flight && branch_i) |=> !err_q);

  p_taken_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_TAKEN && !taken_end_i) |=> (phase_q == PH_TAKEN));

  p_else_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ELSE && !else_end_i) |=> (phase_q == PH_ELSE));

  p_loads_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ld_taken_o, ld_else_o, ld_full_o}));

endmodule

// File: rtl/sds_mask_store.sv
module sds_mask_store #(
  parameter int LANES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] cond_i,
  input  logic             ld_taken_i,
  input  logic             ld_else_i,
  input  logic             ld_full_i,
  output logic [LANES-1:0] mask_o
);

  logic [LANES-1:0] cap_q;
  logic [LANES-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= '0;
      mask_q <= '1;
    end else begin
      if (ld_taken_i) begin
        cap_q  <= cond_i;
        mask_q <= cond_i;
      end else if (ld_else_i) begin
        mask_q <= ~cap_q;
      end else if (ld_full_i) begin
        mask_q <= '1;
      end
    end
  end

  assign mask_o = mask_q;

  p_taken_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_taken_i |=> (mask_q == $past(cond_i)));

  p_else_complement_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_else_i |=> (mask_q == ~$past(mask_q)));

  p_full_restore_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ld_full_i |=> (mask_q == '1));

  p_mask_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_taken_i || ld_else_i || ld_full_i) |=> $stable(mask_q));

endmodule

// File: rtl/simt_div_seq.sv
module simt_div_seq
  import sds_pkg::*;
#(
  parameter int LANES = 32,
  parameter int CNT_W = $clog2(LANES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] cond_i,
  input  logic             branch_i,
  input  logic             taken_end_i,
  input  logic             else_end_i,
  output logic [LANES-1:0] act_mask_o,
  output logic [1:0]       phase_o,
  output logic [CNT_W-1:0] act_cnt_o,
  output logic             branch_err_o
);

  phase_e phase;
  logic   split;
  logic   ld_taken, ld_else, ld_full;

  // a branch diverges only if both sides are populated
  assign split = (|cond_i) && !(&cond_i);

  sds_phase_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .branch_i    (branch_i),
    .split_i     (split),
    .taken_end_i (taken_end_i),
    .else_end_i  (else_end_i),
    .phase_o     (phase),
    .ld_taken_o  (ld_taken),
    .ld_else_o   (ld_else),
    .ld_full_o   (ld_full),
    .err_o       (branch_err_o)
  );

  sds_mask_store #(.LANES(LANES)) u_mask (
    .clk        (clk),
    .rst_n      (rst_n),
    .cond_i     (cond_i),
    .ld_taken_i (ld_taken),
    .ld_else_i  (ld_else),
    .ld_full_i  (ld_full),
    .mask_o     (act_mask_o)
  );

  sds_popcount #(.N(LANES), .CNT_W(CNT_W)) u_cnt (
    .bits_i (act_mask_o),
    .cnt_o  (act_cnt_o)
  );

  assign phase_o = phase;

  p_conv_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CONV) |-> (act_mask_o == '1));

  p_uniform_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CONV && branch_i && !split) |=> (act_mask_o == '1 && phase == PH_CONV));

  p_nested_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_CONV && branch_i && !taken_end_i && !else_end_i)
      |=> ($stable(act_mask_o) && $stable(phase)));

  p_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(act_cnt_o) == $countones(act_mask_o));

  p_partial_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_CONV) |-> (act_mask_o != '0 && act_mask_o != '1));

endmodule

// File: tb/test_simt_div_seq.sv
module test_simt_div_seq;

  localparam int LANES = 32;

  typedef struct {
    logic [31:0] mask;
    logic [1:0]  ph;
    logic [5:0]  cnt;
    logic        err;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cond = '0;
  logic        br = 1'b0, te = 1'b0, ee = 1'b0;
  logic [31:0] mask;
  logic [1:0]  ph;
  logic [5:0]  cnt;
  logic        err;

  int checks = 0, fails = 0, cyc = 0;
  exp_t q[$];

  // reference state, built from the requirements
  logic [1:0]  m_ph   = 2'd0;
  logic [31:0] m_mask = '1;
  logic [31:0] m_cap  = '0;

  always #2 clk = ~clk;

  simt_div_seq i_simt_div_seq (
    .clk(clk), .rst_n(rst_n), .cond_i(cond), .branch_i(br),
    .taken_end_i(te), .else_end_i(ee), .act_mask_o(mask),
    .phase_o(ph), .act_cnt_o(cnt), .branch_err_o(err)
  );

  task automatic step(input logic [31:0] c, input logic b, input logic t,
                      input logic e, input string tag);
    exp_t x;
    logic err_n;
    @(negedge clk);
    cond = c; br = b; te = t; ee = e;
    err_n = 1'b0;
    case (m_ph)
      2'd0: if (b && c != '0 && c != '1) begin m_ph = 2'd1; m_mask = c; m_cap = c; end
      2'd1: begin err_n = b; if (t) begin m_ph = 2'd2; m_mask = ~m_cap; end end
      default: begin err_n = b; if (e) begin m_ph = 2'd0; m_mask = '1; end end
    endcase
    x.mask = m_mask; x.ph = m_ph; x.cnt = 6'($countones(m_mask));
    x.err = err_n; x.tag = tag;
    q.push_back(x);
  endtask

  task automatic idle(input string tag);
    step(cond, 1'b0, 1'b0, 1'b0, tag);
  endtask

  // monitor / scoreboard
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t x;
      x = q.pop_front();
      checks++;
      if (mask !== x.mask || ph !== x.ph || cnt !== x.cnt || err !== x.err) begin
        fails++;
        $display("FAIL %s: got mask=%h ph=%0d cnt=%0d err=%b exp mask=%h ph=%0d cnt=%0d err=%b",
                 x.tag, mask, ph, cnt, err, x.mask, x.ph, x.cnt, x.err);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog: got hang exp completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    checks++;
    if (mask !== '1 || ph !== 2'd0 || cnt !== 6'd32 || err !== 1'b0) begin
      fails++;
      $display("FAIL R1: got mask=%h ph=%0d cnt=%0d err=%b exp ffffffff 0 32 0",
               mask, ph, cnt, err);
    end
    rst_n = 1'b1;
    idle("R1_idle");

    // even lanes: R2, R3, R4, R7 (16 of 32)
    step(32'h5555_5555, 1, 0, 0, "R2_even");
    idle("R7_even_taken");
    step(32'h0, 0, 1, 0, "R3_even");
    idle("R7_even_else");
    step(32'h0, 0, 0, 1, "R4_even");

    // uniform conditions: R5
    step(32'hFFFF_FFFF, 1, 0, 0, "R5_all_ones");
    step(32'h0000_0000, 1, 0, 0, "R5_all_zero");
    idle("R5_after");

    // condition moves after capture: R8
    step(32'h0000_FFFF, 1, 0, 0, "R8_capture");
    step(32'hDEAD_BEEF, 0, 0, 0, "R8_cond_move");
    step(32'h1234_5678, 0, 1, 0, "R8_else_mask");
    step(32'hFFFF_0000, 0, 0, 0, "R8_else_hold");
    step(32'h0, 0, 0, 1, "R8_rejoin");

    // nested branch: R6
    step(32'h0F0F_0F0F, 1, 0, 0, "R6_open");
    step(32'h3333_3333, 1, 0, 0, "R6_nested_taken");
    idle("R6_err_clear");
    step(32'h0, 0, 1, 0, "R6_to_else");
    step(32'hAAAA_AAAA, 1, 0, 0, "R6_nested_else");
    step(32'h0, 1, 0, 1, "R6_nested_with_end");
    idle("R6_after");

    // misplaced end strobes: R9
    step(32'h0, 0, 1, 1, "R9_conv_ends");
    step(32'h0000_0001, 1, 0, 0, "R9_open_lane0");
    step(32'h0, 0, 0, 1, "R9_else_end_in_taken");
    step(32'h0, 0, 1, 0, "R9_to_else");
    step(32'h0, 0, 1, 0, "R9_taken_end_in_else");
    step(32'h0, 0, 0, 1, "R9_rejoin");

    // lane 31 alone, R10 boundary
    step(32'h8000_0000, 1, 0, 0, "R10_lane31");
    step(32'h0, 0, 1, 0, "R10_others");
    step(32'h0, 0, 0, 1, "R10_rejoin");

    // pseudo-random conditions: R2, R3, R7
    lfsr = 32'hACE1_2468;
    for (int k = 0; k < 20; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(lfsr, 1, 0, 0, "R2_rand");
      step(~lfsr, 0, 1, 0, "R3_rand");
      step(lfsr, 0, 0, 1, "R7_rand_rejoin");
    end

    repeat (4) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule